// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block sits on a simple byte-wide I/O bus and provides a two-address configuration window for a legacy peripheral controller. One address holds an index register and the next holds a data register. The window stays locked until software writes an unlock key to the index address. While unlocked, the index picks an internal register and the data address reads or writes that register. A second key locks the window again.

The window's base address comes from a 2-bit strap. The block captures the strap during reset and reports the chosen base through two read-only registers. Software can therefore probe each candidate address: it unlocks, checks the key echo, and then confirms that the reported base matches the address it used.

The programmed values drive a power enable and a high-speed enable for a serial port, plus the serial port's I/O base address. Software changes single bits with read-modify-write, because every data write replaces the whole byte.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The strap value is captured while reset is asserted and selects the base address. Strap 0 selects 0x002E, strap 1 selects 0x004E, strap 2 selects 0x162E and strap 3 selects 0x164E. The index register sits at the base address and the data register at base+1.
- R2: After reset the window is locked, every configuration register is 0x00, and the outputs `uart_pwr_en`, `uart_fast_en` and `uart_base` are all zero.
- R3: While locked, a read of either window address returns 0xFF. Data-port writes and index writes other than 0x55 change nothing.
- R4: Writing 0x55 to the index address while locked unlocks the window and loads the index with 0x55, so the next index read returns 0x55.
- R5: Writing 0xAA to the index address while unlocked locks the window again. Register contents are kept.
- R6: While unlocked, writing any value except 0xAA to the index address loads the index, and an index read returns the index.
- R7: Register 0x12 reads the low byte of the active base and register 0x13 reads the high byte. Writes to either are discarded.
- R8: Register 0x02 stores a full byte. Bit 3 of this register drives `uart_pwr_en`.
- R9: Register 0x0C stores a full byte. Bit 6 of this register drives `uart_fast_en`.
- R10: Register 0x24 stores a full byte, and `uart_base` equals that byte shifted left by two bits (10 bits wide).
- R11: A read of any unimplemented index returns 0x00, and writes to such an index are discarded.
- R12: A read to either window address asserts `rd_ack`, with `rd_data` valid, in the cycle after the request. Reads to any other address never assert `rd_ack`. When a read and a write target the same port in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_sel | input | 2 | Base address select, captured during reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| uart_pwr_en | output | 1 | Serial port power enable |
| uart_fast_en | output | 1 | Serial port high-speed enable |
| uart_base | output | 10 | Serial port I/O base address |

## Verification
A read and a write can land on the data port in the same cycle. Both the captured read value and the register update are then decided by the same clock edge. The bench provokes this by raising both strobes together on register 0x02 while it holds a known value. It expects the old byte back in the response and the new byte on a follow-up read, with `uart_pwr_en` following the new byte. A second overlap pairs an unlock key write with an index read while the window is locked. The response must still be 0xFF, while the next index read returns 0x55.

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int UBW      = 10,
  parameter int BASE0    = 'h002E,
  parameter int BASE1    = 'h004E,
  parameter int BASE2    = 'h162E,
  parameter int BASE3    = 'h164E,
  parameter int KEY_ON   = 'h55,
  parameter int KEY_OFF  = 'hAA,
  parameter int IX_PWR   = 'h02,
  parameter int IX_SPD   = 'h0C,
  parameter int IX_ALO   = 'h12,
  parameter int IX_AHI   = 'h13,
  parameter int IX_UBASE = 'h24,
  parameter int PWR_BIT  = 3,
  parameter int SPD_BIT  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     strap_sel,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic           rd_ack,
  output logic [DW-1:0]  rd_data,
  output logic           uart_pwr_en,
  output logic           uart_fast_en,
  output logic [UBW-1:0] uart_base
);
  localparam int SHIFT = UBW - DW;
  localparam logic [DW-1:0] IDLE_BYTE = '1;

  logic [AW-1:0] base_q, strap_base;
  logic          unlocked;
  logic [DW-1:0] index_q, r_pwr, r_spd, r_ubase, sel_val, rd_val;
  logic          idx_hit, dat_hit;

  always_comb begin
    case (strap_sel)
      2'd0:    strap_base = AW'(BASE0);
      2'd1:    strap_base = AW'(BASE1);
      2'd2:    strap_base = AW'(BASE2);
      default: strap_base = AW'(BASE3);
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) base_q <= strap_base;

  assign idx_hit = bus_addr == base_q;
  assign dat_hit = bus_addr == base_q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      index_q  <= '0;
    end else if (bus_wr && idx_hit) begin
      if (!unlocked) begin
        if (bus_wdata == DW'(KEY_ON)) begin
          unlocked <= 1'b1;
          index_q  <= DW'(KEY_ON);
        end
      end else if (bus_wdata == DW'(KEY_OFF)) begin
        unlocked <= 1'b0;
      end else begin
        index_q <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_pwr   <= '0;
      r_spd   <= '0;
      r_ubase <= '0;
    end else if (bus_wr && dat_hit && unlocked) begin
      case (index_q)
        DW'(IX_PWR):   r_pwr   <= bus_wdata;
        DW'(IX_SPD):   r_spd   <= bus_wdata;
        DW'(IX_UBASE): r_ubase <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (index_q)
      DW'(IX_PWR):   sel_val = r_pwr;
      DW'(IX_SPD):   sel_val = r_spd;
      DW'(IX_UBASE): sel_val = r_ubase;
      DW'(IX_ALO):   sel_val = base_q[DW-1:0];
      DW'(IX_AHI):   sel_val = DW'(base_q >> DW);
      default:       sel_val = '0;
    endcase
  end

  assign rd_val = !unlocked ? IDLE_BYTE : (idx_hit ? index_q : sel_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= bus_rd && (idx_hit || dat_hit);
      if (bus_rd && (idx_hit || dat_hit)) rd_data <= rd_val;
    end
  end

  assign uart_pwr_en  = r_pwr[PWR_BIT];
  assign uart_fast_en = r_spd[SPD_BIT];
  assign uart_base    = {r_ubase, SHIFT'(0)};

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (idx_hit || dat_hit) && !unlocked) |=> (rd_ack && rd_data == IDLE_BYTE));

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(r_pwr) && $stable(r_spd) && $stable(r_ubase)));

  assert_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx_hit && !unlocked && bus_wdata == DW'(KEY_ON)) |=> (unlocked && index_q == DW'(KEY_ON)));

  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx_hit && unlocked && bus_wdata == DW'(KEY_OFF)) |=> !unlocked);

  assert_ack_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (idx_hit || dat_hit)) |=> !rd_ack);

  assert_base_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(base_q));
endmodule

// File: tb/cfg_port_ctrl_tb.sv
module cfg_port_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] strap_sel = 0;
  logic [15:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic rd_ack;
  logic [7:0] rd_data;
  logic uart_pwr_en, uart_fast_en;
  logic [9:0] uart_base;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [15:0] base;

  always #10 clk = ~clk;

  cfg_port_ctrl u_dut (.clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_ack(rd_ack), .rd_data(rd_data),
    .uart_pwr_en(uart_pwr_en), .uart_fast_en(uart_fast_en), .uart_base(uart_base));

  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected ack: actual %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s read: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] e, string t);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rdwr(logic [15:0] a, logic [7:0] d, logic [7:0] e, string t);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_wr = 0; bus_rd = 0;
  endtask

  task automatic do_reset(logic [1:0] s);
    @(negedge clk); rst_n = 0; strap_sel = s;
    repeat (2) @(negedge clk);
    rst_n = 1; strap_sel = ~s;
    @(negedge clk);
  endtask

  task automatic finish_run;
    repeat (3) @(negedge clk);
    check("R12 pending reads", 16'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    base = 16'h002E;
    do_reset(0);
    check("R2 pwr", 16'(uart_pwr_en), 0);
    check("R2 fast", 16'(uart_fast_en), 0);
    check("R2 ubase", 16'(uart_base), 0);
    check("R2 ack", 16'(rd_ack), 0);
    // R3 locked behaviour
    rd(base, 8'hFF, "R3 idx locked");
    rd(base + 1, 8'hFF, "R3 data locked");
    wr(base + 1, 8'hFF);
    wr(base, 8'h02);
    wr(base + 1, 8'hFF);
    check("R3 pwr unchanged", 16'(uart_pwr_en), 0);
    // R12 overlap: key write with index read while locked
    rdwr(base, 8'h55, 8'hFF, "R12 key+read");
    rd(base, 8'h55, "R4 key echo");
    wr(base, 8'h12); rd(base + 1, 8'h2E, "R7 low");
    wr(base + 1, 8'h99); rd(base + 1, 8'h2E, "R7 low ro");
    wr(base, 8'h13); rd(base + 1, 8'h00, "R7 high");
    wr(base, 8'h02); wr(base + 1, 8'h08);
    check("R8 pwr on", 16'(uart_pwr_en), 1);
    rd(base + 1, 8'h08, "R8 read");
    wr(base + 1, 8'hF7);
    check("R8 pwr off", 16'(uart_pwr_en), 0);
    rd(base + 1, 8'hF7, "R8 full byte");
    rdwr(base + 1, 8'h08, 8'hF7, "R12 rd+wr old");
    rd(base + 1, 8'h08, "R12 rd+wr new");
    check("R12 pwr after overlap", 16'(uart_pwr_en), 1);
    wr(base, 8'h0C); wr(base + 1, 8'h40);
    check("R9 fast", 16'(uart_fast_en), 1);
    wr(base + 1, 8'hBF);
    check("R9 fast off", 16'(uart_fast_en), 0);
    wr(base, 8'h24); wr(base + 1, 8'hFE);
    check("R10 ubase", 16'(uart_base), 16'h3F8);
    rd(base + 1, 8'hFE, "R10 read");
    wr(base, 8'h30); rd(base, 8'h30, "R6 index");
    wr(base + 1, 8'h5A); rd(base + 1, 8'h00, "R11 unimpl");
    wr(base, 8'h55); rd(base, 8'h55, "R6 0x55 as index");
    rd(16'h004E, 8'h00, "R12 miss");
    void'(exp_q.pop_back()); void'(tag_q.pop_back());
    check("R12 no ack on miss", 16'(rd_ack), 0);
    // R5 lock
    wr(base, 8'h02);
    wr(base, 8'hAA);
    rd(base, 8'hFF, "R5 locked idx");
    wr(base + 1, 8'h00);
    check("R5 pwr kept", 16'(uart_pwr_en), 1);
    wr(base, 8'h55); wr(base, 8'h02);
    rd(base + 1, 8'h08, "R5 reg kept");
    // R1 strap choices
    for (int s = 1; s < 4; s++) begin
      case (s)
        1: base = 16'h004E;
        2: base = 16'h162E;
        default: base = 16'h164E;
      endcase
      do_reset(2'(s));
      check("R2 pwr after reset", 16'(uart_pwr_en), 0);
      rd(16'h002E, 8'h00, "R1 old base");
      void'(exp_q.pop_back()); void'(tag_q.pop_back());
      check("R1 old base no ack", 16'(rd_ack), 0);
      wr(base, 8'h55);
      wr(base, 8'h12); rd(base + 1, base[7:0], "R1 low");
      wr(base, 8'h13); rd(base + 1, base[15:8], "R1 high");
      wr(base, 8'h24); rd(base + 1, 8'h00, "R2 ubase zero");
    end
    finish_run();
  end
endmodule